// File: doc/BRIEF.md
# Pause/PFC transmit request controller

This block decides when a link should emit XON and XOFF flow-control frames on behalf of up to eight traffic queues. Each queue turns a request into frame events. The request is either a level on a CSR bit or a two-bit command, which comes from CSR bits or from a pair of external pins. A queue in the XOFF state re-issues XOFF whenever its hold timer runs out. Pending events from all queues are merged by a round-robin arbiter into one frame descriptor. The descriptor carries the frame type, the two addresses, a class-enable vector and one quanta value per class. A MAC transmit path takes it over a valid/ready handshake.

A small write/read register port sets up the block. The map is listed in R1. The hold timer counts pause quanta. One quantum is approximated by a programmable number of clock cycles.

Top module: `pfc_tx_ctrl`

## Requirements
- R1: After reset the registers read as follows. Offset 0x01 (queue enables, bit q per queue) reads all ones. Offset 0x03 (bit0 two-bit mode, bit1 queue-0 PFC select, bit2 pause-transmission enable) reads 0x2. Offset 0x04 (source select, bit q) reads 0. Offsets 0x05/0x06 (destination low 32 / high 16) read 0xC2000001/0x0180. Offsets 0x07/0x08 (source low / high) read 0xCBFC5ADD/0xE100. Offset 0x09 (cycles per quantum) reads the QCYC_RST parameter. Offsets 0x10+q (quanta) and 0x18+q (hold) read 0xFFFF. No descriptor is valid.
- R2: A queue whose enable bit is 0 produces no frame event for any request, and never appears in a descriptor's class-enable vector.
- R3: In one-bit mode (0x03 bit0 = 0) the request of queue q is bit q of offset 0x02. A rise sends XOFF with the queue's quanta. A fall sends one XON with quanta 0.
- R4: In two-bit mode the command is {high, low}. 2'b01 sends XOFF. 2'b10 sends XON, and only when the queue is in XOFF. 2'b00 and 2'b11 cause no frame.
- R5: In two-bit mode a source-select bit of 1 takes low/high from bits q and 16+q of offset 0x02. A source-select bit of 0 takes them from the pins req_pin_lo[q]/req_pin_hi[q], and the CSR bits are then ignored.
- R6: While XOFF stays requested, XOFF is re-sent each time the hold timer expires. Two consecutive XOFF frames of a queue are between (H-1)*C+1 and H*C+1 cycles apart, where H is the hold value and C the cycles per quantum.
- R7: With 0x03 bit1 = 0, queue 0 is sent alone as a classic Pause frame: fc_pfc = 0 and the class-enable vector is 1. With bit1 = 1 it is sent as a PFC class.
- R8: All PFC events pending when a descriptor is formed go into that one descriptor. It has class-enable bit q set for each queue sent. Slot q of fc_quanta (bits 16q+15:16q) holds the quanta for an XOFF and 0 for an XON or an absent class.
- R9: While fc_valid is high and fc_ready is low, the descriptor and fc_valid hold steady.
- R10: The descriptor carries the programmed destination and source addresses.
- R11: The scratch register (0x00) and the pause-transmission enable (0x03 bit2) read back what was written and do not cause frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| req_pin_lo | input | NQ | Low command bit per queue from pins |
| req_pin_hi | input | NQ | High command bit per queue from pins |
| fc_valid | output | 1 | Descriptor valid |
| fc_ready | input | 1 | Descriptor accepted by transmit path |
| fc_pfc | output | 1 | 1 = PFC frame, 0 = classic Pause |
| fc_cls_en | output | NQ | Class-enable vector |
| fc_quanta | output | NQ*16 | Quanta per class, slot q at 16q |
| fc_dst | output | 48 | Destination address |
| fc_src | output | 48 | Source address |

## Verification
The assertions take for granted that register writes that change enables, the mode, the source selects or the addresses never fall while a descriptor is being formed in a way that needs two settings at once. They also take for granted that fc_ready is an ordinary level the transmit path may drop at any time. The stimulus therefore changes configuration only while no request is active and the descriptor path is idle. It toggles fc_ready only around a single pending frame. Requests are always returned to the neutral value before the mode or the sources change.

// File: rtl/pfc_tx_pkg.sv
package pfc_tx_pkg;
  localparam int AW   = 6;
  localparam int MAXQ = 8;

  localparam logic [AW-1:0] A_SCRATCH = 6'h00;
  localparam logic [AW-1:0] A_ENABLE  = 6'h01;
  localparam logic [AW-1:0] A_REQ     = 6'h02;
  localparam logic [AW-1:0] A_CTRL    = 6'h03;
  localparam logic [AW-1:0] A_SRCSEL  = 6'h04;
  localparam logic [AW-1:0] A_DST_LO  = 6'h05;
  localparam logic [AW-1:0] A_DST_HI  = 6'h06;
  localparam logic [AW-1:0] A_SRC_LO  = 6'h07;
  localparam logic [AW-1:0] A_SRC_HI  = 6'h08;
  localparam logic [AW-1:0] A_QCYC    = 6'h09;
  localparam logic [AW-1:0] A_QNT     = 6'h10;
  localparam logic [AW-1:0] A_HOLD    = 6'h18;

  localparam logic [47:0] DST_RST = 48'h0180_C200_0001;
  localparam logic [47:0] SRC_RST = 48'hE100_CBFC_5ADD;
endpackage

// File: rtl/pfc_tx_csr.sv
module pfc_tx_csr
  import pfc_tx_pkg::*;
#(
  parameter int NQ       = 4,
  parameter int QCYC_RST = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NQ-1:0]        en,
  output logic [NQ-1:0]        req_lo,
  output logic [NQ-1:0]        req_hi,
  output logic [NQ-1:0]        srcsel,
  output logic                 mode2,
  output logic                 q0_pfc,
  output logic [47:0]          dst,
  output logic [47:0]          src,
  output logic [15:0]          qcyc,
  output logic [NQ-1:0][15:0]  quanta,
  output logic [NQ-1:0][15:0]  hold
);
  logic [31:0] scratch;
  logic        pause_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch  <= '0;
      en       <= '1;
      req_lo   <= '0;
      req_hi   <= '0;
      srcsel   <= '0;
      mode2    <= 1'b0;
      q0_pfc   <= 1'b1;
      pause_en <= 1'b0;
      dst      <= DST_RST;
      src      <= SRC_RST;
      qcyc     <= 16'(QCYC_RST);
    end else if (wr) begin
      case (addr)
        A_SCRATCH: scratch <= wdata;
        A_ENABLE:  en      <= wdata[NQ-1:0];
        A_REQ: begin
          req_lo <= wdata[NQ-1:0];
          req_hi <= wdata[16 +: NQ];
        end
        A_CTRL: begin
          mode2    <= wdata[0];
          q0_pfc   <= wdata[1];
          pause_en <= wdata[2];
        end
        A_SRCSEL: srcsel       <= wdata[NQ-1:0];
        A_DST_LO: dst[31:0]    <= wdata;
        A_DST_HI: dst[47:32]   <= wdata[15:0];
        A_SRC_LO: src[31:0]    <= wdata;
        A_SRC_HI: src[47:32]   <= wdata[15:0];
        A_QCYC:   qcyc         <= wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quanta <= '1;
      hold   <= '1;
    end else if (wr) begin
      for (int q = 0; q < NQ; q++) begin
        if (addr == A_QNT + AW'(q))  quanta[q] <= wdata[15:0];
        if (addr == A_HOLD + AW'(q)) hold[q]   <= wdata[15:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_SCRATCH: rdata = scratch;
      A_ENABLE:  rdata[NQ-1:0] = en;
      A_REQ: begin
        rdata[NQ-1:0]  = req_lo;
        rdata[16 +: NQ] = req_hi;
      end
      A_CTRL:    rdata[2:0] = {pause_en, q0_pfc, mode2};
      A_SRCSEL:  rdata[NQ-1:0] = srcsel;
      A_DST_LO:  rdata = dst[31:0];
      A_DST_HI:  rdata[15:0] = dst[47:32];
      A_SRC_LO:  rdata = src[31:0];
      A_SRC_HI:  rdata[15:0] = src[47:32];
      A_QCYC:    rdata[15:0] = qcyc;
      default: ;
    endcase
    for (int q = 0; q < NQ; q++) begin
      if (addr == A_QNT + AW'(q))  rdata[15:0] = quanta[q];
      if (addr == A_HOLD + AW'(q)) rdata[15:0] = hold[q];
    end
  end
endmodule

// File: rtl/pfc_tx_queue.sv
module pfc_tx_queue (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        mode2,
  input  logic        srcsel,
  input  logic        csr_lo,
  input  logic        csr_hi,
  input  logic        pin_lo,
  input  logic        pin_hi,
  input  logic        tick,
  input  logic [15:0] hold,
  input  logic        take,
  output logic        pend,
  output logic        pend_xoff
);
  logic        st_q, st_n;
  logic        pend_q, pend_n;
  logic        typ_q, typ_n;
  logic [15:0] tmr_q, tmr_n;
  logic        lo, hi, off_req, on_req, fire_off, fire_on;

  always_comb begin
    lo       = (mode2 && !srcsel) ? pin_lo : csr_lo;
    hi       = (mode2 && !srcsel) ? pin_hi : csr_hi;
    off_req  = mode2 ? ({hi, lo} == 2'b01) : lo;
    on_req   = mode2 ? ({hi, lo} == 2'b10) : !lo;
    fire_off = en && off_req && (!st_q || tmr_q == 16'd0);
    fire_on  = en && on_req && st_q;

    st_n   = st_q;
    tmr_n  = tmr_q;
    pend_n = pend_q;
    typ_n  = typ_q;
    if (!en) begin
      st_n   = 1'b0;
      tmr_n  = '0;
      pend_n = 1'b0;
    end else begin
      if (tick && tmr_q != 16'd0) tmr_n = tmr_q - 16'd1;
      if (take) pend_n = 1'b0;
      if (fire_off) begin
        st_n   = 1'b1;
        tmr_n  = hold;
        pend_n = 1'b1;
        typ_n  = 1'b1;
      end else if (fire_on) begin
        st_n   = 1'b0;
        pend_n = 1'b1;
        typ_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b0;
      tmr_q  <= '0;
      pend_q <= 1'b0;
      typ_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      tmr_q  <= tmr_n;
      pend_q <= pend_n;
      typ_q  <= typ_n;
    end
  end

  assign pend      = pend_q & en;
  assign pend_xoff = typ_q;
endmodule

// File: rtl/pfc_tx_arb.sv
module pfc_tx_arb #(
  parameter int NQ = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       pend,
  input  logic [NQ-1:0]       pend_xoff,
  input  logic [NQ-1:0][15:0] quanta,
  input  logic                q0_pfc,
  input  logic [47:0]         dst,
  input  logic [47:0]         src,
  input  logic                ready,
  output logic [NQ-1:0]       take,
  output logic                valid,
  output logic                pfc,
  output logic [NQ-1:0]       cls,
  output logic [NQ*16-1:0]    qout,
  output logic [47:0]         dst_o,
  output logic [47:0]         src_o
);
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [NQ-1:0] Q0_BIT = NQ'(1);

  logic [IW-1:0]    ptr_q, ptr_n, sel;
  logic             found, load, pause_c, valid_n;
  logic [NQ-1:0]    cls_c;
  logic [NQ*16-1:0] q_c;
  int               idx;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < NQ; k++) begin
      idx = (int'(ptr_q) + k) % NQ;
      if (!found && pend[idx]) begin
        found = 1'b1;
        sel   = IW'(idx);
      end
    end
    load    = found && (!valid || ready);
    pause_c = (sel == '0) && !q0_pfc;
    cls_c   = pause_c ? Q0_BIT : (pend & ~(q0_pfc ? '0 : Q0_BIT));
    for (int q = 0; q < NQ; q++)
      q_c[16*q +: 16] = (cls_c[q] && pend_xoff[q]) ? quanta[q] : 16'd0;
    take    = load ? cls_c : '0;
    ptr_n   = load ? IW'((int'(sel) + 1) % NQ) : ptr_q;
    valid_n = load || (valid && !ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ptr_q <= '0;
    end else begin
      valid <= valid_n;
      ptr_q <= ptr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      pfc   <= !pause_c;
      cls   <= cls_c;
      qout  <= q_c;
      dst_o <= dst;
      src_o <= src;
    end
  end
endmodule

// File: rtl/pfc_tx_ctrl.sv
module pfc_tx_ctrl
  import pfc_tx_pkg::*;
#(
  parameter int NQ       = 4,
  parameter int QCYC_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [5:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [NQ-1:0]    req_pin_lo,
  input  logic [NQ-1:0]    req_pin_hi,
  output logic             fc_valid,
  input  logic             fc_ready,
  output logic             fc_pfc,
  output logic [NQ-1:0]    fc_cls_en,
  output logic [NQ*16-1:0] fc_quanta,
  output logic [47:0]      fc_dst,
  output logic [47:0]      fc_src
);
  logic [1:0]           rs_q;
  logic                 rst_i;
  logic [NQ-1:0]        en_w, lo_w, hi_w, sel_w, pend_w, xoff_w, take_w;
  logic                 mode2_w, q0pfc_w, tick;
  logic [47:0]          dst_w, src_w;
  logic [15:0]          qcyc_w, cnt_q, cnt_n;
  logic [NQ-1:0][15:0]  qnt_w, hold_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    tick  = ({1'b0, cnt_q} + 17'd1) >= {1'b0, qcyc_w};
    cnt_n = tick ? 16'd0 : cnt_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  pfc_tx_csr #(.NQ(NQ), .QCYC_RST(QCYC_RST)) u_csr (
    .clk(clk), .rst_n(rst_i), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en(en_w), .req_lo(lo_w), .req_hi(hi_w), .srcsel(sel_w),
    .mode2(mode2_w), .q0_pfc(q0pfc_w), .dst(dst_w), .src(src_w), .qcyc(qcyc_w),
    .quanta(qnt_w), .hold(hold_w)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    pfc_tx_queue u_q (
      .clk(clk), .rst_n(rst_i), .en(en_w[q]), .mode2(mode2_w), .srcsel(sel_w[q]),
      .csr_lo(lo_w[q]), .csr_hi(hi_w[q]), .pin_lo(req_pin_lo[q]), .pin_hi(req_pin_hi[q]),
      .tick(tick), .hold(hold_w[q]), .take(take_w[q]),
      .pend(pend_w[q]), .pend_xoff(xoff_w[q])
    );
  end

  pfc_tx_arb #(.NQ(NQ)) u_arb (
    .clk(clk), .rst_n(rst_i), .pend(pend_w), .pend_xoff(xoff_w), .quanta(qnt_w),
    .q0_pfc(q0pfc_w), .dst(dst_w), .src(src_w), .ready(fc_ready), .take(take_w),
    .valid(fc_valid), .pfc(fc_pfc), .cls(fc_cls_en), .qout(fc_quanta),
    .dst_o(fc_dst), .src_o(fc_src)
  );
endmodule

// File: rtl/pfc_tx_chk.sv
module pfc_tx_chk #(
  parameter int NQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NQ-1:0]    en,
  input logic             fc_valid,
  input logic             fc_ready,
  input logic             fc_pfc,
  input logic [NQ-1:0]    fc_cls_en,
  input logic [NQ*16-1:0] fc_quanta,
  input logic [47:0]      fc_dst,
  input logic [47:0]      fc_src
);
  // R9
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid && !fc_ready |=> fc_valid && $stable(fc_cls_en) && $stable(fc_quanta)
      && $stable(fc_pfc) && $stable(fc_dst) && $stable(fc_src));

  // R8
  cls_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid |-> fc_cls_en != '0);

  // R7
  pause_q0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid && !fc_pfc |-> fc_cls_en == NQ'(1));

  // R2
  disabled_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fc_valid && !$past(fc_valid && !fc_ready) |-> (fc_cls_en & ~$past(en)) == '0);

  for (genvar g = 0; g < NQ; g++) begin : g_slot
    // R8
    idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fc_valid && !fc_cls_en[g] |-> fc_quanta[16*g +: 16] == 16'd0);
  end
endmodule

bind pfc_tx_ctrl pfc_tx_chk #(.NQ(NQ)) u_pfc_tx_chk (
  .clk(clk), .rst_n(rst_i), .en(en_w), .fc_valid(fc_valid), .fc_ready(fc_ready),
  .fc_pfc(fc_pfc), .fc_cls_en(fc_cls_en), .fc_quanta(fc_quanta),
  .fc_dst(fc_dst), .fc_src(fc_src)
);

// File: tb/pfc_tx_ctrl_bench.sv
module pfc_tx_ctrl_bench;
  localparam int NQ = 4;

  logic             clk = 1'b0;
  logic             rst_n, cfg_wr, fc_ready, fc_valid, fc_pfc;
  logic [5:0]       cfg_addr;
  logic [31:0]      cfg_wdata, cfg_rdata;
  logic [NQ-1:0]    req_pin_lo, req_pin_hi, fc_cls_en;
  logic [NQ*16-1:0] fc_quanta;
  logic [47:0]      fc_dst, fc_src;

  always #2 clk = ~clk;

  pfc_tx_ctrl #(.NQ(NQ), .QCYC_RST(4)) u_pfc_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_pin_lo(req_pin_lo), .req_pin_hi(req_pin_hi),
    .fc_valid(fc_valid), .fc_ready(fc_ready), .fc_pfc(fc_pfc), .fc_cls_en(fc_cls_en),
    .fc_quanta(fc_quanta), .fc_dst(fc_dst), .fc_src(fc_src)
  );

  typedef struct packed {
    logic             pfc;
    logic [NQ-1:0]    cls;
    logic [NQ*16-1:0] qnt;
    logic [47:0]      dst;
    logic [47:0]      src;
  } desc_t;

  desc_t       expq[$];
  string       tagq[$];
  int          acc_cyc[$];
  int          n_chk = 0, n_err = 0, cyc = 0;
  logic [15:0] qv [NQ];
  logic [47:0] cur_dst = 48'h0180_C200_0001;
  logic [47:0] cur_src = 48'hE100_CBFC_5ADD;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string rq, input logic [199:0] act, input logic [199:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic desc_t mk(input bit pfc, input logic [NQ-1:0] cls, input bit xoff);
    desc_t d;
    d.pfc = pfc; d.cls = cls; d.dst = cur_dst; d.src = cur_src;
    for (int q = 0; q < NQ; q++) d.qnt[16*q +: 16] = (cls[q] && xoff) ? qv[q] : 16'd0;
    return d;
  endfunction

  task automatic push(input string tag, input bit pfc, input logic [NQ-1:0] cls, input bit xoff);
    expq.push_back(mk(pfc, cls, xoff));
    tagq.push_back(tag);
  endtask

  task automatic wcfg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rchk(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); cfg_addr = a; #1;
    check(cfg_rdata == e, tag, 200'(cfg_rdata), 200'(e));
  endtask

  task automatic drain(input string tag);
    for (int w = 0; w < 300 && expq.size() != 0; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(expq.size() == 0, {tag, " frames delivered"}, 200'(expq.size()), 200'(0));
  endtask

  task automatic quiet(input string tag);
    repeat (20) @(negedge clk);
    check(!fc_valid && expq.size() == 0, {tag, " no frame"}, 200'(fc_valid), 200'(0));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fc_valid && fc_ready) begin
      desc_t act;
      act = '{fc_pfc, fc_cls_en, fc_quanta, fc_dst, fc_src};
      acc_cyc.push_back(cyc);
      if (expq.size() == 0) check(1'b0, "unexpected frame", 200'(act), 200'(0));
      else begin
        desc_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(act == e, t, 200'(act), 200'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_pin_lo = '0; req_pin_hi = '0; fc_ready = 1'b1;
    qv[0] = 16'h0A00; qv[1] = 16'h0011; qv[2] = 16'h0222; qv[3] = 16'h0303;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    check(!fc_valid, "R1 valid idle", 200'(fc_valid), 200'(0));
    rchk(6'h01, 32'hF, "R1 enable");
    rchk(6'h03, 32'h2, "R1 ctrl");
    rchk(6'h04, 32'h0, "R1 srcsel");
    rchk(6'h05, 32'hC200_0001, "R1 dst lo");
    rchk(6'h06, 32'h0180, "R1 dst hi");
    rchk(6'h07, 32'hCBFC_5ADD, "R1 src lo");
    rchk(6'h08, 32'hE100, "R1 src hi");
    rchk(6'h09, 32'd4, "R1 qcyc");
    rchk(6'h12, 32'hFFFF, "R1 quanta");
    rchk(6'h1B, 32'hFFFF, "R1 hold");

    for (int q = 0; q < NQ; q++) wcfg(6'h10 + 6'(q), 32'(qv[q]));

    // R3 one-bit level on queue 1
    push("R3 xoff q1", 1'b1, 4'b0010, 1'b1);
    wcfg(6'h02, 32'h2);
    drain("R3 xoff");
    push("R3 xon q1", 1'b1, 4'b0010, 1'b0);
    wcfg(6'h02, 32'h0);
    drain("R3 xon");

    // R2 disabled queue 2 ignores request
    wcfg(6'h01, 32'hB);
    wcfg(6'h02, 32'h4);
    quiet("R2 disabled");
    wcfg(6'h02, 32'h0);
    quiet("R2 disabled release");
    wcfg(6'h01, 32'hF);

    // R8 two queues combined into one descriptor
    push("R8 combined xoff", 1'b1, 4'b0110, 1'b1);
    wcfg(6'h02, 32'h6);
    drain("R8 xoff");
    push("R8 combined xon", 1'b1, 4'b0110, 1'b0);
    wcfg(6'h02, 32'h0);
    drain("R8 xon");

    // R7 queue 0 classic Pause
    wcfg(6'h03, 32'h0);
    push("R7 pause xoff", 1'b0, 4'b0001, 1'b1);
    wcfg(6'h02, 32'h1);
    drain("R7 xoff");
    push("R7 pause xon", 1'b0, 4'b0001, 1'b0);
    wcfg(6'h02, 32'h0);
    drain("R7 xon");
    wcfg(6'h03, 32'h2);

    // R4 two-bit commands from CSR on queue 3
    wcfg(6'h03, 32'h3);
    wcfg(6'h04, 32'h8);
    push("R4 cmd01 xoff", 1'b1, 4'b1000, 1'b1);
    wcfg(6'h02, 32'h0000_0008);
    drain("R4 xoff");
    wcfg(6'h02, 32'h0008_0008);
    quiet("R4 cmd11");
    push("R4 cmd10 xon", 1'b1, 4'b1000, 1'b0);
    wcfg(6'h02, 32'h0008_0000);
    drain("R4 xon");
    wcfg(6'h02, 32'h0);
    wcfg(6'h02, 32'h0008_0000);
    quiet("R4 xon while not xoff");
    wcfg(6'h02, 32'h0);

    // R5 pin source on queue 1; CSR bits ignored
    wcfg(6'h02, 32'h2);
    quiet("R5 csr ignored");
    wcfg(6'h02, 32'h0);
    push("R5 pin xoff", 1'b1, 4'b0010, 1'b1);
    @(negedge clk); req_pin_lo = 4'b0010;
    drain("R5 xoff");
    push("R5 pin xon", 1'b1, 4'b0010, 1'b0);
    @(negedge clk); req_pin_lo = 4'b0000; req_pin_hi = 4'b0010;
    drain("R5 xon");
    @(negedge clk); req_pin_hi = 4'b0000;
    wcfg(6'h03, 32'h2);
    wcfg(6'h04, 32'h0);

    // R9 backpressure holds descriptor
    @(negedge clk); fc_ready = 1'b0;
    push("R9 held frame", 1'b1, 4'b0100, 1'b1);
    wcfg(6'h02, 32'h4);
    repeat (10) @(negedge clk);
    check(fc_valid && fc_cls_en == 4'b0100, "R9 held", 200'({fc_valid, fc_cls_en}), 200'({1'b1, 4'b0100}));
    @(negedge clk); fc_ready = 1'b1;
    drain("R9 release");
    push("R9 xon", 1'b1, 4'b0100, 1'b0);
    wcfg(6'h02, 32'h0);
    drain("R9 xon");

    // R10 programmed addresses
    wcfg(6'h05, 32'h1122_3344);
    wcfg(6'h06, 32'h0000_5566);
    wcfg(6'h07, 32'h99AA_BBCC);
    wcfg(6'h08, 32'h0000_7788);
    cur_dst = 48'h5566_1122_3344;
    cur_src = 48'h7788_99AA_BBCC;
    push("R10 addr xoff", 1'b1, 4'b1000, 1'b1);
    wcfg(6'h02, 32'h8);
    drain("R10 xoff");
    push("R10 addr xon", 1'b1, 4'b1000, 1'b0);
    wcfg(6'h02, 32'h0);
    drain("R10 xon");

    // R11 scratch and pause enable
    wcfg(6'h00, 32'hA5A5_5A5A);
    wcfg(6'h03, 32'h6);
    rchk(6'h00, 32'hA5A5_5A5A, "R11 scratch");
    rchk(6'h03, 32'h6, "R11 pause enable");
    quiet("R11 no effect");
    wcfg(6'h03, 32'h2);

    // R6 XOFF repeat at hold expiry, H=4 C=2
    wcfg(6'h09, 32'd2);
    wcfg(6'h19, 32'd4);
    acc_cyc.delete();
    push("R6 xoff 1", 1'b1, 4'b0010, 1'b1);
    push("R6 xoff 2", 1'b1, 4'b0010, 1'b1);
    push("R6 xoff 3", 1'b1, 4'b0010, 1'b1);
    wcfg(6'h02, 32'h2);
    for (int w = 0; w < 200 && acc_cyc.size() < 3; w++) @(posedge clk);
    push("R6 xon", 1'b1, 4'b0010, 1'b0);
    wcfg(6'h02, 32'h0);
    drain("R6 repeat");
    check(acc_cyc.size() == 4, "R6 frame count", 200'(acc_cyc.size()), 200'(4));
    if (acc_cyc.size() >= 3) begin
      for (int i = 1; i < 3; i++)
        check(acc_cyc[i] - acc_cyc[i-1] >= 7 && acc_cyc[i] - acc_cyc[i-1] <= 9,
              "R6 spacing", 200'(acc_cyc[i] - acc_cyc[i-1]), 200'(8));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule